// File: doc/BRIEF.md
# Group-Synchronised Buffered PWM Bank

This block holds a small bank of PWM generators. Each generator has its own period, duty and phase offset, and it runs an up-counter from its working values. Software writes new values into holding registers at any time. These writes never touch the running waveform. A generator's working set changes only by a buffered transfer, and that transfer lands on a cycle boundary.

A transfer starts with one request on the master generator, which is generator 0. One cycle after the request bit is set, it is broadcast to every generator in the bank and the request bit clears itself. Each generator then marks a pending flag. It copies its holding values into its working set at its own next cycle start, and clears its flag at the same moment. Software can read the pending flags to learn when every transfer has finished. The last generator raises a one-cycle start-of-cycle pulse. Software can use that pulse to time its next request, so that the transfer has the most room before the first generator wraps again.

The register interface uses one address per register. Address bits [1:0] select the field: 0 is period, 1 is duty, 2 is phase and 3 is control/status. The upper address bits select the generator. The bank supports variable frequency because the period is also a buffered parameter.

Top module: `pwm_group_sync`

## Requirements
- R1: While reset is active and right after it, every output is low, every pending flag and the request bit are 0, and each working set is period PER_RST, duty 0 and phase 0.
- R2: A write to field 0, 1 or 2 of any generator updates only that generator's holding register. It changes no output until a transfer is applied.
- R3: A write with data bit 0 set to field 3 of generator 0 sets the request bit. The request bit reads back as bit 1 of generator 0's status in the next cycle.
- R4: One cycle after the request bit is set, every generator's pending flag is 1 and the request bit is 0. The pending flag reads back as bit 0 of that generator's field 3.
- R5: A write to field 3 of any generator other than generator 0 has no effect on the request bit, on the pending flags or on the outputs.
- R6: The counter of each generator counts from 0 to period−1 and then wraps. The output is high exactly while the counter is below the working duty.
- R7: A pending generator copies period, duty and phase from its holding registers at the edge where its counter wraps, and its pending flag clears at that same edge. No transfer ever happens in the middle of a cycle.
- R8: `socEvent` is high for exactly the first clock of each cycle of the last generator.
- R9: A working duty at or above the working period keeps the output high for the whole cycle. A working duty of 0 keeps it low.
- R10: When a transfer is applied, the counter restarts at the new phase offset instead of 0.
- R11: A request made while transfers are still pending merges with them. The next cycle start applies the latest holding values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | GIDX_W+2 | Register address: {generator, field} |
| wrData | input | CNT_W | Register write data |
| rdData | output | CNT_W | Status read data; bit 0 is pending, bit 1 is request (generator 0 only) |
| pwmOut | output | NUM_GEN | One PWM output per generator |
| socEvent | output | 1 | Start-of-cycle pulse of the last generator |

## Verification
A write sampled at edge E takes effect after E. A request written at E shows as the request bit after E, and it becomes pending flags after E+1. The working values and the counter restart change at the first wrap edge after that. The start-of-cycle pulse appears in the clock that follows a wrap of the last generator. Status reads are combinational from the flags and the current address. The bench drives its inputs 2 ns after a rising edge and moves an expected item for every edge through a queue. It compares outputs and read data at the falling edge of the same cycle, so each register stage is counted exactly once.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  // Field selector taken from the two low address bits
  typedef enum logic [1:0] {
    FLD_PERIOD = 2'd0,
    FLD_DUTY   = 2'd1,
    FLD_PHASE  = 2'd2,
    FLD_CTRL   = 2'd3
  } regField_e;

  // Strobes from control to datapath for holding-register writes
  typedef struct packed {
    logic      holdWr;
    regField_e field;
  } holdStb_t;

endpackage

// File: rtl/pwm_upd_ctrl.sv
module pwm_upd_ctrl
  import pwm_sync_pkg::*;
#(
  parameter int NUM_GEN = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               reqDataBit,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_GEN-1:0] wrapVec,
  output holdStb_t           stb,
  output logic [NUM_GEN-1:0] genSel,
  output logic [NUM_GEN-1:0] applyVec,
  output logic [NUM_GEN-1:0] pendVec,
  output logic               reqBit
);

  localparam int GIDX_W = ADDR_W - 2;

  logic [GIDX_W-1:0] gIdx;
  regField_e         fld;
  logic              inRange;
  logic              reqSet;

  assign gIdx    = addr[ADDR_W-1:2];
  assign fld     = regField_e'(addr[1:0]);
  assign inRange = int'(gIdx) < NUM_GEN;

  assign stb.holdWr = wrEn && inRange && (fld != FLD_CTRL);
  assign stb.field  = fld;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_sel
    assign genSel[g] = (int'(gIdx) == g);
  end

  // Only the master window accepts an update request
  assign reqSet = wrEn && (gIdx == '0) && (fld == FLD_CTRL) && reqDataBit;

  // Request lasts one cycle: it is broadcast, then clears itself
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBit  <= 1'b0;
      pendVec <= '0;
    end else begin
      reqBit  <= reqSet;
      pendVec <= reqBit ? '1 : (pendVec & ~wrapVec);
    end
  end

  assign applyVec = pendVec & wrapVec;

  always_comb begin
    rdData = '0;
    if (inRange && (fld == FLD_CTRL)) begin
      rdData[0] = pendVec[gIdx];
      rdData[1] = (gIdx == '0) && reqBit;
    end
  end

endmodule

// File: rtl/pwm_gen_bank.sv
module pwm_gen_bank
  import pwm_sync_pkg::*;
#(
  parameter int NUM_GEN = 4,
  parameter int CNT_W   = 8,
  parameter int PER_RST = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  holdStb_t           stb,
  input  logic [NUM_GEN-1:0] genSel,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [NUM_GEN-1:0] applyVec,
  output logic [NUM_GEN-1:0] wrapVec,
  output logic [NUM_GEN-1:0] pwmOut,
  output logic               socEvent
);

  localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(PER_RST);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W:0]   EXT_ONE  = (CNT_W+1)'(1);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic [CNT_W-1:0] holdPer, holdDuty, holdPh;
    logic [CNT_W-1:0] workPer, workDuty, cnt;
    logic             holdHit;

    assign holdHit = stb.holdWr && genSel[g];

    // Holding set: written from the register interface at any time
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdPer  <= PER_INIT;
        holdDuty <= '0;
        holdPh   <= '0;
      end else if (holdHit) begin
        case (stb.field)
          FLD_PERIOD: holdPer  <= wrData;
          FLD_DUTY:   holdDuty <= wrData;
          FLD_PHASE:  holdPh   <= wrData;
          default:    ;
        endcase
      end
    end

    // Last count of the cycle; also covers period 0 and 1
    assign wrapVec[g] = ({1'b0, cnt} + EXT_ONE) >= {1'b0, workPer};

    // Working set and counter: change only at a cycle start
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        workPer  <= PER_INIT;
        workDuty <= '0;
        cnt      <= '0;
      end else if (applyVec[g]) begin
        workPer  <= holdPer;
        workDuty <= holdDuty;
        cnt      <= holdPh;
      end else if (wrapVec[g]) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + CNT_ONE;
      end
    end

    assign pwmOut[g] = cnt < workDuty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) socEvent <= 1'b0;
    else       socEvent <= wrapVec[NUM_GEN-1];
  end

endmodule

// File: rtl/pwm_group_sync.sv
module pwm_group_sync
  import pwm_sync_pkg::*;
#(
  parameter  int NUM_GEN = 4,
  parameter  int CNT_W   = 8,
  parameter  int PER_RST = 8,
  localparam int GIDX_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
  localparam int ADDR_W  = GIDX_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wrData,
  output logic [CNT_W-1:0]   rdData,
  output logic [NUM_GEN-1:0] pwmOut,
  output logic               socEvent
);

  holdStb_t           stb;
  logic [NUM_GEN-1:0] genSel;
  logic [NUM_GEN-1:0] applyVec;
  logic [NUM_GEN-1:0] wrapVec;
  logic [NUM_GEN-1:0] pendVec;
  logic               reqBit;

  pwm_upd_ctrl #(
    .NUM_GEN(NUM_GEN), .DATA_W(CNT_W), .ADDR_W(ADDR_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .reqDataBit(wrData[0]), .rdData(rdData), .wrapVec(wrapVec),
    .stb(stb), .genSel(genSel), .applyVec(applyVec),
    .pendVec(pendVec), .reqBit(reqBit)
  );

  pwm_gen_bank #(
    .NUM_GEN(NUM_GEN), .CNT_W(CNT_W), .PER_RST(PER_RST)
  ) i_bank (
    .clk(clk), .rstN(rstN), .stb(stb), .genSel(genSel),
    .wrData(wrData), .applyVec(applyVec), .wrapVec(wrapVec),
    .pwmOut(pwmOut), .socEvent(socEvent)
  );

endmodule

// File: rtl/pwm_group_sync_chk.sv
module pwm_group_sync_chk #(
  parameter int NUM_GEN = 4,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic               dataBit0,
  input logic               socEvent,
  input logic [NUM_GEN-1:0] wrapVec,
  input logic [NUM_GEN-1:0] pendVec,
  input logic               reqBit
);

  localparam logic [ADDR_W-1:0] MST_CTRL = ADDR_W'(3);

  logic mstReq;
  logic otherCtrl;
  assign mstReq    = wrEn && (addr == MST_CTRL) && dataBit0;
  assign otherCtrl = wrEn && (addr[1:0] == 2'b11) && (addr[ADDR_W-1:2] != '0);

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rstN) |-> (pendVec == '0) && !reqBit && !socEvent);

  a_r3_req_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    mstReq |=> reqBit);

  a_r4_bcast_sets_pend: assert property (@(posedge clk) disable iff (!rstN)
    reqBit |=> (pendVec == '1));

  a_r4_req_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (reqBit && !mstReq) |=> !reqBit);

  a_r5_other_ctrl_ignored: assert property (@(posedge clk) disable iff (!rstN)
    otherCtrl |=> !reqBit);

  a_r8_soc_after_wrap: assert property (@(posedge clk) disable iff (!rstN)
    wrapVec[NUM_GEN-1] |=> socEvent);

  a_r8_soc_only_after_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !wrapVec[NUM_GEN-1] |=> !socEvent);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_pend
    // R7: a pending flag only drops at a cycle start of its generator
    a_r7_pend_clears_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pendVec[g]) |-> $past(wrapVec[g]));
  end

endmodule

bind pwm_group_sync pwm_group_sync_chk #(
  .NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .dataBit0(wrData[0]),
  .socEvent(socEvent), .wrapVec(wrapVec), .pendVec(pendVec), .reqBit(reqBit)
);

// File: tb/test_pwm_group_sync.sv
module test_pwm_group_sync;

  localparam int NG = 4;
  localparam int PR = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  wire  [7:0] rdData;
  wire  [3:0] pwmOut;
  wire        socEvent;

  always #10 clk = ~clk;

  pwm_group_sync #(.NUM_GEN(NG), .CNT_W(8), .PER_RST(PR)) i_pwm_group_sync (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwmOut), .socEvent(socEvent)
  );

  typedef struct packed {
    logic [3:0] pwm;
    logic       soc;
    logic [3:0] pend;
    logic       req;
    logic [7:0] tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int curTag = 1;

  // Reference model built from the requirements
  int mPer[NG], mDuty[NG], mCnt[NG], hPer[NG], hDuty[NG], hPh[NG];
  bit mPend[NG];
  bit mReq, mSoc, nextReq, lastWrap, wrapNow;
  expItem_t pushIt, popIt;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < NG; g++) begin
        mPer[g] = PR; mDuty[g] = 0; mCnt[g] = 0;
        hPer[g] = PR; hDuty[g] = 0; hPh[g] = 0; mPend[g] = 0;
      end
      mReq = 0; mSoc = 0;
    end else begin
      nextReq  = wrEn && (addr == 4'b0011) && wrData[0];   // R3
      lastWrap = 0;
      for (int g = 0; g < NG; g++) begin
        wrapNow = (mCnt[g] + 1) >= mPer[g];                  // R6
        if (mPend[g] && wrapNow) begin                        // R7 R10
          mPer[g] = hPer[g]; mDuty[g] = hDuty[g]; mCnt[g] = hPh[g];
        end else if (wrapNow) mCnt[g] = 0;
        else mCnt[g] = mCnt[g] + 1;
        mPend[g] = mReq ? 1'b1 : (wrapNow ? 1'b0 : mPend[g]); // R4
        if (g == NG - 1) lastWrap = wrapNow;
      end
      mSoc = lastWrap;                                        // R8
      if (wrEn && addr[1:0] == 2'd0) hPer[addr[3:2]]  = wrData; // R2
      if (wrEn && addr[1:0] == 2'd1) hDuty[addr[3:2]] = wrData;
      if (wrEn && addr[1:0] == 2'd2) hPh[addr[3:2]]   = wrData;
      mReq = nextReq;
    end
    for (int g = 0; g < NG; g++) begin
      pushIt.pwm[g]  = mCnt[g] < mDuty[g];
      pushIt.pend[g] = mPend[g];
    end
    pushIt.soc = mSoc;
    pushIt.req = mReq;
    pushIt.tag = 8'(curTag);
    expQ.push_back(pushIt);
  end

  task automatic chk(int tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per edge, compares at the falling edge
  logic [7:0] rdExp;
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      popIt = expQ.pop_front();
      rdExp = '0;
      if (addr[1:0] == 2'b11) begin
        rdExp[0] = popIt.pend[addr[3:2]];
        rdExp[1] = (addr[3:2] == 2'd0) && popIt.req;
      end
      chk(int'(popIt.tag), "pwmOut", int'(pwmOut), int'(popIt.pwm));
      chk(int'(popIt.tag), "socEvent", int'(socEvent), int'(popIt.soc));
      chk(int'(popIt.tag), "rdData", int'(rdData), int'(rdExp));
    end
  end

  task automatic wr(int g, int f, int v);
    wrEn = 1'b1; addr = {2'(g), 2'(f)}; wrData = 8'(v);
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic idle(int n, int g);
    wrEn = 1'b0; addr = {2'(g), 2'b11};
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  int hiCnt, loCnt;

  initial begin
    // R1: reset state
    curTag = 1;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    idle(6, 0);

    // R2: holding writes leave outputs alone
    curTag = 2;
    for (int g = 0; g < NG; g++) begin
      wr(g, 0, 10);
      wr(g, 1, 3 + g);
      wr(g, 2, 2 * g);
    end
    idle(20, 1);

    // R3: master request bit reads back one cycle later
    curTag = 3;
    wr(0, 3, 1);
    idle(1, 0);
    // R4: broadcast sets every pending flag, request clears
    curTag = 4;
    idle(1, 2);
    // R7 R10 R6: transfer at each cycle start, phase reload, then steady PWM
    curTag = 7;
    idle(12, 3);
    curTag = 10;
    idle(10, 1);
    curTag = 6;
    idle(12, 0);

    // R5: control write outside the master window does nothing
    curTag = 5;
    wr(2, 3, 1);
    wr(2, 1, 9);
    idle(25, 2);

    // R11: second request while flags pending merges to latest values
    curTag = 11;
    wr(0, 3, 1);
    idle(2, 1);
    wr(1, 1, 7);
    wr(0, 3, 1);
    idle(25, 1);

    // R8: new period on the last generator changes the pulse rate
    curTag = 8;
    wr(3, 0, 5);
    wr(3, 2, 0);
    wr(0, 3, 1);
    idle(25, 3);

    // R9: duty at or above period stays high, duty 0 stays low
    curTag = 9;
    wr(0, 1, 200);
    wr(1, 1, 0);
    wr(0, 3, 1);
    idle(25, 0);
    hiCnt = 0; loCnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwmOut[0]) hiCnt++;
      if (!pwmOut[1]) loCnt++;
    end
    @(posedge clk); #2;
    chk(9, "gen0 high cycles (R9)", hiCnt, 20);
    chk(9, "gen1 low cycles (R9)", loCnt, 20);
    idle(3, 0);
    summary();
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout, expected completion");
    summary();
  end

endmodule